// File: doc/BRIEF.md
# Serial Configuration Register Slave for a Clock Synthesizer

This block is a two-wire serial bus slave that owns a bank of eight-bit configuration registers for a clock synthesizer. A fast system clock oversamples the bus clock and data lines. Both lines pass through two-flop synchronizers, and START and STOP conditions are detected from the synchronized samples. The slave answers one fixed device address, whose write form is 0xD2 and whose read form is 0xD3. It drives SDA only by pulling it low.

Writes are block writes only. After the address, the master sends a command byte and then a count byte. The slave acknowledges both and discards their values. Every data byte that follows lands in the next register, always starting at register 0. Each byte is first collected in a shift register. On its acknowledge it is committed to the live register, or it is parked in a pair holding slot if it is the low half of a paired register.

Reads return a count byte first, then registers 0 through N, where N is the value held in the count register (index 8). The rest of the chip sees the whole bank in parallel, together with a one-cycle load strobe for each register.

Top module: `cfg_serial_slave`

## Requirements
- R1: The slave acknowledges an address byte of 0xD2 (write) or 0xD3 (read). Any other address byte is not acknowledged, and the slave ignores the rest of that transaction, so no register changes.
- R2: In a write, the first two bytes after the address (command and count) are acknowledged and their values are discarded. The first data byte goes to register 0.
- R3: Write data bytes fill registers in ascending order from register 0. On a STOP after any complete byte, every byte already acknowledged is kept.
- R4: Data bytes sent beyond register 20 are acknowledged and change no register.
- R5: Registers 11/12 and registers 13/14 form two pairs. A pair updates only when both of its bytes arrive in the same transaction. Otherwise neither register of the pair changes.
- R6: A data byte of 0x00 aimed at register 8 is ignored, and register 8 keeps its previous value.
- R7: A read sends the value of register 8 first, then registers 0 through that value, one register per byte, and then 0xFF for every further byte the master acknowledges.
- R8: After the master does not acknowledge a read byte, the slave keeps SDA released until the next START, and after any STOP it releases SDA on the next cycle.
- R9: Reset leaves SDA released, all load strobes low, and these register values: registers 1–6 are 0xFF, register 8 is 0x08, register 9 is 0x10, and all other registers are 0x00.
- R10: A register's value changes only in the cycle its load strobe is high. The strobe is high for exactly one cycle per accepted byte, and both registers of a pair strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial bus clock line as seen on the pin |
| sda_i | input | 1 | Serial bus data line as seen on the pin |
| sda_oe_o | output | 1 | High to pull SDA low (acknowledge or a zero data bit) |
| cfg_regs_o | output | NREGS*8 | Register bank, register i at bits [8i+7:8i] |
| cfg_load_o | output | NREGS | One-cycle load strobe per register |

## Verification
The bench builds the slave with its default parameters: 21 registers, two-stage synchronizers, the count register at index 8, and pairs starting at 11 and 13. With 21 registers, a handful of block writes covers every register and the writes past the end of the bank. Stopping after byte 11 and after byte 13 exercises both halves of the pair rule. A zero aimed at register 8 tests the rule that protects the count register. The bench also runs reads at the default and at a reduced count, and keeps acknowledging past the last register so that the 0xFF fill and the release after a NACK can be checked.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK,
    ST_WAIT
  } cfgs_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } cfgs_phase_t;

  // Power-on value of register idx; cnt_idx is the readback-length register.
  function automatic logic [7:0] reg_default(input int idx, input int cnt_idx);
    if (idx == cnt_idx)                 return 8'h08;
    else if (idx == cnt_idx + 1)        return 8'h10;
    else if (idx >= 1 && idx <= 6)      return 8'hFF;
    else                                return 8'h00;
  endfunction

endpackage

// File: rtl/cfgs_busmon.sv
module cfgs_busmon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] scl_p, sda_p;
  logic scl_now, scl_old, sda_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  assign scl_now   = scl_p[STAGES-1];
  assign scl_old   = scl_p[STAGES];
  assign sda_s     = sda_p[STAGES-1];
  assign sda_old   = sda_p[STAGES];
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_evt = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_evt  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/cfgs_regbank.sv
module cfgs_regbank
  import cfgs_pkg::*;
#(
  parameter int NREGS    = 21,
  parameter int PW       = 9,
  parameter int CNT_IDX  = 8,
  parameter int PAIR0_LO = 11,
  parameter int PAIR1_LO = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [PW-1:0]      wr_idx,
  input  logic [7:0]         wr_data,
  input  logic               abort,
  output logic [NREGS*8-1:0] regs_o,
  output logic [NREGS-1:0]   stb_o
);
  localparam logic [PW-1:0] CNT_W = PW'(CNT_IDX);
  localparam logic [PW-1:0] P0L_W = PW'(PAIR0_LO);
  localparam logic [PW-1:0] P1L_W = PW'(PAIR1_LO);

  logic [7:0]    mem [NREGS];
  logic [7:0]    hold;
  logic [PW-1:0] hold_idx;
  logic          hold_vld;
  logic          is_lo, is_hi, pair_ok;

  assign is_lo   = (wr_idx == P0L_W) || (wr_idx == P1L_W);
  assign is_hi   = (wr_idx == P0L_W + PW'(1)) || (wr_idx == P1L_W + PW'(1));
  assign pair_ok = hold_vld && (hold_idx + PW'(1) == wr_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= reg_default(i, CNT_IDX);
      stb_o    <= '0;
      hold     <= '0;
      hold_idx <= '0;
      hold_vld <= 1'b0;
    end else begin
      stb_o <= '0;
      if (abort) begin
        hold_vld <= 1'b0;
      end else if (wr_en) begin
        if (is_lo) begin
          hold     <= wr_data;
          hold_idx <= wr_idx;
          hold_vld <= 1'b1;
        end else if (is_hi) begin
          hold_vld <= 1'b0;
          if (pair_ok) begin
            for (int i = 0; i < NREGS; i++) begin
              if (PW'(i) == hold_idx) begin
                mem[i]   <= hold;
                stb_o[i] <= 1'b1;
              end else if (PW'(i) == wr_idx) begin
                mem[i]   <= wr_data;
                stb_o[i] <= 1'b1;
              end
            end
          end
        end else if (!(wr_idx == CNT_W && wr_data == 8'h00)) begin
          for (int i = 0; i < NREGS; i++) begin
            if (PW'(i) == wr_idx) begin
              mem[i]   <= wr_data;
              stb_o[i] <= 1'b1;
            end
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_flat
    assign regs_o[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
  import cfgs_pkg::*;
#(
  parameter int         NREGS       = 21,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2,
  parameter int         CNT_IDX     = 8,
  parameter int         PAIR0_LO    = 11,
  parameter int         PAIR1_LO    = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [NREGS*8-1:0] cfg_regs_o,
  output logic [NREGS-1:0]   cfg_load_o
);
  // pointer must reach past both the bank and any count register value
  localparam int PW = ($clog2(NREGS + 1) > 8) ? $clog2(NREGS + 1) + 1 : 9;
  localparam logic [PW-1:0] NREGS_W = PW'(NREGS);

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  cfgs_busmon #(.STAGES(SYNC_STAGES)) busmon_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  cfgs_state_t   st;
  cfgs_phase_t   phase;
  logic [7:0]    sh, txsh, tx_next, cnt_val;
  logic [3:0]    bitc;
  logic          rd_mode, nack;
  logic [PW-1:0] ptr;
  logic          wr_en;
  logic [PW-1:0] wr_idx;
  logic [7:0]    wr_data;
  logic [7:0]    regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_unflat
    assign regs[g] = cfg_regs_o[g*8 +: 8];
  end

  assign cnt_val = regs[CNT_IDX];

  always_comb begin
    tx_next = 8'hFF;
    for (int i = 0; i < NREGS; i++)
      if (PW'(i) == ptr && ptr <= PW'(cnt_val)) tx_next = regs[i];
  end

  cfgs_regbank #(
    .NREGS(NREGS), .PW(PW), .CNT_IDX(CNT_IDX),
    .PAIR0_LO(PAIR0_LO), .PAIR1_LO(PAIR1_LO)
  ) bank_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .abort(start_evt | stop_evt), .regs_o(cfg_regs_o), .stb_o(cfg_load_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      phase    <= PH_ADDR;
      sh       <= '0;
      txsh     <= '0;
      bitc     <= '0;
      rd_mode  <= 1'b0;
      nack     <= 1'b0;
      ptr      <= '0;
      sda_oe_o <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        st       <= ST_RX;
        phase    <= PH_ADDR;
        bitc     <= '0;
        ptr      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_evt) begin
        st       <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise && bitc < 4'd8) begin
              sh   <= {sh[6:0], sda_s};
              bitc <= bitc + 4'd1;
            end else if (scl_fall && bitc == 4'd8) begin
              bitc <= '0;
              if (phase == PH_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rd_mode  <= sh[0];
                  sda_oe_o <= 1'b1;
                  st       <= ST_RXACK;
                  phase    <= PH_CMD;
                end else begin
                  st <= ST_WAIT;
                end
              end else begin
                sda_oe_o <= 1'b1;
                st       <= ST_RXACK;
                if (phase == PH_CMD) phase <= PH_CNT;
                else if (phase == PH_CNT) phase <= PH_DATA;
                else if (ptr < NREGS_W) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= sh;
                  ptr     <= ptr + PW'(1);
                end
              end
            end
          end
          ST_RXACK: begin
            if (scl_fall) begin
              bitc <= '0;
              if (rd_mode) begin
                txsh     <= cnt_val;
                sda_oe_o <= ~cnt_val[7];
                st       <= ST_TX;
              end else begin
                sda_oe_o <= 1'b0;
                st       <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitc == 4'd7) begin
                sda_oe_o <= 1'b0;
                bitc     <= '0;
                st       <= ST_TXACK;
              end else begin
                txsh     <= {txsh[6:0], 1'b0};
                sda_oe_o <= ~txsh[6];
                bitc     <= bitc + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) nack <= sda_s;
            else if (scl_fall) begin
              if (nack) st <= ST_WAIT;
              else begin
                txsh     <= tx_next;
                sda_oe_o <= ~tx_next[7];
                st       <= ST_TX;
                if (ptr != '1) ptr <= ptr + PW'(1);
              end
            end
          end
          default: sda_oe_o <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk #(
  parameter int NREGS    = 21,
  parameter int CNT_IDX  = 8,
  parameter int PAIR0_LO = 11,
  parameter int PAIR1_LO = 13
) (
  input logic               clk,
  input logic               rst,
  input logic               sda_oe,
  input logic [NREGS*8-1:0] regs_flat,
  input logic [NREGS-1:0]   stb,
  input logic               stop_evt
);
  // R9: first cycle out of reset is quiet
  a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_oe && stb == '0));

  // R8: STOP releases the data line on the next cycle
  a_r8_release_after_stop: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe);

  // R5: both halves of a pair strobe together
  a_r5_pair0_together: assert property (@(posedge clk) disable iff (rst)
    stb[PAIR0_LO] == stb[PAIR0_LO+1]);
  a_r5_pair1_together: assert property (@(posedge clk) disable iff (rst)
    stb[PAIR1_LO] == stb[PAIR1_LO+1]);

  // R6: the readback-length register never holds zero
  a_r6_count_nonzero: assert property (@(posedge clk) disable iff (rst)
    regs_flat[CNT_IDX*8 +: 8] != 8'h00);

  // R10: a register value moves only with its strobe
  for (genvar g = 0; g < NREGS; g++) begin : g_chg
    a_r10_change_has_strobe: assert property (@(posedge clk) disable iff (rst)
      (regs_flat[g*8 +: 8] != $past(regs_flat[g*8 +: 8])) |-> stb[g]);
  end
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(
  .NREGS(NREGS), .CNT_IDX(CNT_IDX), .PAIR0_LO(PAIR0_LO), .PAIR1_LO(PAIR1_LO)
) chk_i (
  .clk(clk), .rst(rst), .sda_oe(sda_oe_o), .regs_flat(cfg_regs_o),
  .stb(cfg_load_o), .stop_evt(stop_evt)
);

// File: tb/cfg_serial_slave_tb_top.sv
module cfg_serial_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 16;
  localparam int NR         = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [NR*8-1:0] regs;
  logic [NR-1:0]   stb;

  int tests = 0;
  int fails = 0;
  logic [7:0] expv [NR];
  logic [7:0] wbuf [32];
  int stb_cnt [NR];
  logic watch_oe = 1'b0;
  logic oe_seen  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  cfg_serial_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .cfg_regs_o(regs), .cfg_load_o(stb)
  );

  always @(posedge clk) begin
    for (int i = 0; i < NR; i++) if (stb[i]) stb_cnt[i] = stb_cnt[i] + 1;
    if (watch_oe && sda_oe) oe_seen = 1'b1;
  end

  function automatic logic [7:0] dflt(input int i);
    if (i == 8) return 8'h08;
    if (i == 9) return 8'h10;
    if (i >= 1 && i <= 6) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int k = 7; k >= 0; k--) begin
      sda_m = b[k]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    acked = (sda_line == 1'b0);
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int k = 7; k >= 0; k--) begin
      wq(); scl_m = 1'b1; wq(); b[k] = sda_line; wq(); scl_m = 1'b0;
    end
    sda_m = ~mack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < NR; i++) chk(32'(regs[i*8 +: 8]), 32'(expv[i]), tag);
  endtask

  // block write of n data bytes from wbuf; model follows R2..R6
  task automatic do_write(input int n, input string tag);
    logic a;
    for (int i = 0; i < NR; i++) stb_cnt[i] = 0;
    bus_start();
    send_byte(8'hD2, a); chk(32'(a), 1, "R1 write address ack");
    send_byte(8'hA5, a); chk(32'(a), 1, "R2 command ack");
    send_byte(8'h77, a); chk(32'(a), 1, "R2 count ack");
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      chk(32'(a), 1, (i >= NR) ? "R4 ack past bank" : "R3 data ack");
    end
    bus_stop();
    for (int i = 0; i < n && i < NR; i++) begin
      if (i == 11 || i == 13) begin
        if (i + 1 < n) begin
          expv[i] = wbuf[i]; expv[i+1] = wbuf[i+1];
        end
        i++;
      end else if (!(i == 8 && wbuf[i] == 8'h00)) begin
        expv[i] = wbuf[i];
      end
    end
    check_bank(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R9: reset state
    for (int i = 0; i < NR; i++) expv[i] = dflt(i);
    check_bank("R9 reset value");
    chk(32'(sda_oe), 0, "R9 sda released");
    chk(32'(stb), 0, "R9 strobes low");

    // R7: default read returns count 8 then registers 0..8, then 0xFF
    bus_start();
    send_byte(8'hD3, a); chk(32'(a), 1, "R1 read address ack");
    recv_byte(1'b1, b); chk(32'(b), 8, "R7 count byte");
    for (int i = 0; i <= 8; i++) begin
      recv_byte(1'b1, b); chk(32'(b), 32'(dflt(i)), "R7 read data");
    end
    recv_byte(1'b0, b); chk(32'(b), 32'hFF, "R7 fill past count");
    // R8: released after master NACK
    watch_oe = 1'b1; oe_seen = 1'b0;
    for (int k = 0; k < 9; k++) begin
      wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0;
    end
    wq();
    watch_oe = 1'b0;
    chk(32'(oe_seen), 0, "R8 no drive after nack");
    bus_stop();

    // R1: foreign address is not acked and its data is ignored
    bus_start();
    send_byte(8'hA4, a); chk(32'(a), 0, "R1 foreign address nack");
    send_byte(8'h00, a); send_byte(8'h00, a); send_byte(8'h00, a);
    chk(32'(a), 0, "R1 foreign data nack");
    bus_stop();
    check_bank("R1 bank unchanged");

    // R2 R3 R4 R5 R10: full write running past the bank
    for (int i = 0; i < 24; i++) wbuf[i] = pat(i);
    do_write(24, "R3 full write");
    for (int i = 0; i < NR; i++) chk(32'(stb_cnt[i]), 1, "R10 one strobe per reg");

    // R3 R5: stop after low half of first pair
    for (int i = 0; i < 12; i++) wbuf[i] = ~pat(i);
    do_write(12, "R5 first pair held");
    chk(32'(stb_cnt[11]), 0, "R5 no strobe lone low half");

    // R5: first pair complete, second pair incomplete
    for (int i = 0; i < 14; i++) wbuf[i] = pat(i) ^ 8'h3C;
    do_write(14, "R5 second pair held");

    // R6: zero to count register ignored
    for (int i = 0; i < 9; i++) wbuf[i] = pat(i);
    wbuf[8] = 8'h00;
    do_write(9, "R6 count zero ignored");
    chk(32'(regs[8*8 +: 8]), 32'h11, "R6 count kept");

    // R7: shortened read length
    for (int i = 0; i < 9; i++) wbuf[i] = pat(i) + 8'd1;
    wbuf[8] = 8'h04;
    do_write(9, "R7 set length");
    bus_start();
    send_byte(8'hD3, a); chk(32'(a), 1, "R1 read address ack");
    recv_byte(1'b1, b); chk(32'(b), 4, "R7 count byte short");
    for (int i = 0; i <= 4; i++) begin
      recv_byte(1'b1, b); chk(32'(b), 32'(expv[i]), "R7 read data short");
    end
    recv_byte(1'b1, b); chk(32'(b), 32'hFF, "R7 fill acked");
    recv_byte(1'b0, b); chk(32'(b), 32'hFF, "R7 fill last");
    bus_stop();
    chk(32'(sda_oe), 0, "R8 released after stop");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule